// File: doc/BRIEF.md
# Transaction-Complete Descriptor Address Queue

This block keeps a record of which endpoints have finished a transfer. Each time an IN or OUT transaction completes, the controller presents the endpoint's 16-bit descriptor table address together with a one-cycle strobe. The block stores that address in a circular queue of 2-byte slots held in shared byte-addressed memory directly below a programmable base address. The memory itself is outside the block, so the block only drives the byte writes into it.

The producer and consumer positions are 5-bit registers kept in one's-complement form, so they read as negative offsets. The byte address of a slot is the base plus twice the sign-extended pointer, which places every slot below the base. Storing an entry moves the producer pointer downward, and the pointers wrap after the configured depth. Software reads either pointer through a small register port. A read of the consumer pointer returns its value and pops one entry. A read of the producer pointer changes nothing. A level-style pending flag reports that entries are waiting, and a sticky overflow bit records completions that were lost because the queue was full.

Top module: `tc_desc_queue`

## Requirements
- R1: After reset, both pointers read 5'h1F (logical slot 0), `pending_o` and `overflow_o` are 0, `mem_we_o` is 0 and `rd_data_o` is 0.
- R2: A completion accepted at a clock edge produces two consecutive byte writes, one per cycle, starting in the following cycle. The low byte `desc_i[7:0]` goes to address A = `base_i` + 2 × (sign-extended producer pointer). The high byte `desc_i[15:8]` then goes to A+1.
- R3: The producer pointer decreases by one (5-bit, one's-complement form) at the clock edge that ends the high-byte write, and not earlier.
- R4: A pointer whose logical slot is DEPTH−1 (stored value ~(DEPTH−1)) returns to 5'h1F on its next step. This applies to both pointers.
- R5: A read with `rd_sel_i`=0 returns the producer pointer in `rd_data_o` in the cycle after the request and has no side effect.
- R6: A read with `rd_sel_i`=1 returns the consumer pointer as it was before the read. If the queue is not empty, the consumer pointer then decreases by one.
- R7: A consumer read while the queue is empty leaves the consumer pointer unchanged.
- R8: `pending_o` is 1 exactly when the two pointers differ, that is, when the entry count (producer slot minus consumer slot, modulo DEPTH) is non-zero.
- R9: The queue is full at DEPTH−1 entries. A completion accepted while the queue is full causes no memory write and no pointer change, and it sets `overflow_o`, which then stays at 1 until reset.
- R10: A completion strobe that arrives while the two byte writes are in progress (`busy_o`=1) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_i | input | 16 | Byte address the queue sits below |
| done_i | input | 1 | Transaction completion strobe |
| desc_i | input | 16 | Descriptor table address of the finished endpoint |
| busy_o | output | 1 | Byte writes in progress; completions are ignored |
| mem_we_o | output | 1 | Memory byte write enable |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| rd_en_i | input | 1 | Pointer register read request |
| rd_sel_i | input | 1 | 0 selects the producer pointer, 1 selects the consumer pointer (pop) |
| rd_data_o | output | 5 | Pointer value returned by the last read |
| pending_o | output | 1 | Entries waiting in the queue |
| overflow_o | output | 1 | Sticky flag for a completion lost to a full queue |

## Verification
Completions, consumer pops and producer reads are mixed at random with random descriptors and base addresses. This drives the slot address through every position and across the wrap, and separates a correct sign extension and scaling from an off-by-one slot. Directed sequences cover several cases: filling to DEPTH−1 and then one more completion, which tells a dropped entry from an overwrite; popping an empty queue, which tells a guarded pop from a free-running one; and a strobe held high during the byte writes, which shows whether a second entry gets in. Each operation is followed by a check of the pending flag against the model's entry count, so a flag that follows the wrong condition is caught.

// File: rtl/tcq_pkg.sv
package tcq_pkg;
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_LO   = 2'd1,
    WR_HI   = 2'd2
  } wr_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/tcq_ring_ptr.sv
module tcq_ring_ptr #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] nxt_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  assign nxt_o = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  assign idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= nxt_o;
  end

  a_r4_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q == LAST) |=> (idx_q == '0));

  a_r3_step_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (idx_q != $past(idx_q)));

  a_r3_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q));
endmodule

// File: rtl/tcq_writer.sv
module tcq_writer
  import tcq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PTR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2*BYTE_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PTR_W-1:0]  slot_ptr_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o
);
  wr_state_e         state_q;
  logic [2*BYTE_W-1:0] desc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] slot_off;

  // signed pointer scaled by the 2-byte slot size
  assign slot_off = {{(ADDR_W-PTR_W-1){slot_ptr_i[PTR_W-1]}}, slot_ptr_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      desc_q  <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        WR_IDLE: if (start_i) begin
          state_q <= WR_LO;
          desc_q  <= desc_i;
          addr_q  <= base_i + slot_off;
        end
        WR_LO:   state_q <= WR_HI;
        WR_HI:   state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != WR_IDLE);
  assign commit_o    = (state_q == WR_HI);
  assign mem_we_o    = busy_o;
  assign mem_addr_o  = (state_q == WR_HI) ? addr_q + 1'b1 : addr_q;
  assign mem_wdata_o = (state_q == WR_HI) ? desc_q[2*BYTE_W-1:BYTE_W] : desc_q[BYTE_W-1:0];

  a_r2_high_follows_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !commit_o) |=> (mem_we_o && commit_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

  a_r10_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  a_r2_write_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mem_we_o && !commit_o));
endmodule

// File: rtl/tc_desc_queue.sv
module tc_desc_queue
  import tcq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              done_i,
  input  logic [15:0]       desc_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [PTR_W-1:0]  rd_data_o,
  output logic              pending_o,
  output logic              overflow_o
);
  logic [PTR_W-1:0] p_idx, p_nxt, c_idx, c_nxt;
  logic [PTR_W-1:0] p_ptr, c_ptr;
  logic             commit, empty, full, accept, drop, start, pop;
  logic             ovf_q;
  logic [PTR_W-1:0] rd_q;

  generate
    if (DEPTH < 2 || DEPTH > 16) begin : g_bad_depth
      initial $error("tc_desc_queue: DEPTH must be 2..16");
    end
  endgenerate

  tcq_ring_ptr #(.DEPTH(DEPTH), .IDX_W(PTR_W)) u_prod (
    .clk_i (clk_i), .rst_ni(rst_ni), .step_i(commit),
    .idx_o (p_idx), .nxt_o (p_nxt)
  );

  tcq_ring_ptr #(.DEPTH(DEPTH), .IDX_W(PTR_W)) u_cons (
    .clk_i (clk_i), .rst_ni(rst_ni), .step_i(pop),
    .idx_o (c_idx), .nxt_o (c_nxt)
  );

  // stored form is the one's complement of the logical slot
  assign p_ptr = ~p_idx;
  assign c_ptr = ~c_idx;

  assign empty  = (p_idx == c_idx);
  assign full   = (p_nxt == c_idx);
  assign accept = done_i && !busy_o;
  assign drop   = accept && full;
  assign start  = accept && !full;
  assign pop    = rd_en_i && rd_sel_i && !empty;

  tcq_writer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .desc_i     (desc_i),
    .base_i     (base_i),
    .slot_ptr_i (p_ptr),
    .busy_o     (busy_o),
    .commit_o   (commit),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (drop)    ovf_q <= 1'b1;
      if (rd_en_i) rd_q  <= rd_sel_i ? c_ptr : p_ptr;
    end
  end

  assign rd_data_o  = rd_q;
  assign overflow_o = ovf_q;
  assign pending_o  = !empty || full;

  a_r7_empty_pop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i && empty) |=> $stable(c_idx));

  a_r6_pop_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (c_idx == $past(c_nxt)));

  a_r5_prod_read_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_sel_i && !commit) |=> $stable(p_idx));

  a_r9_drop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> (!mem_we_o && overflow_o));

  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r8_last_pop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && c_nxt == p_idx && !commit) |=> !pending_o);
endmodule

// File: tb/sim_tc_desc_queue.sv
`timescale 1ns/1ps
module sim_tc_desc_queue;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] base_i = 16'h4000;
  logic        done_i = 1'b0;
  logic [15:0] desc_i = '0;
  logic        busy_o, mem_we_o, pending_o, overflow_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        rd_en_i = 1'b0, rd_sel_i = 1'b0;
  logic [4:0]  rd_data_o;

  int n_chk = 0, n_fail = 0;
  int ip = 0, ic = 0;
  bit ov = 0;

  always #2.5 clk_i = ~clk_i;

  tc_desc_queue #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .done_i(done_i), .desc_i(desc_i),
    .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .pending_o(pending_o), .overflow_o(overflow_o)
  );

  function automatic int cnt();
    return (ip - ic + DEPTH) % DEPTH;
  endfunction
  function automatic logic [4:0] enc(int idx);
    return ~5'(idx);
  endfunction
  function automatic logic [15:0] slot_addr(logic [15:0] b, int idx);
    return b - 16'(2 * (idx + 1));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check_flags();
    check(pending_o == (cnt() != 0), "R8 pending", pending_o, cnt() != 0);
    check(overflow_o == ov, "R9 overflow", overflow_o, ov);
  endtask

  // completion; hold_busy keeps done_i high through the first write cycle
  task automatic complete(logic [15:0] d, bit hold_busy);
    logic [15:0] a;
    desc_i = d; done_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    if (cnt() == DEPTH - 1) begin
      done_i = 1'b0;
      ov = 1;
      check(mem_we_o == 1'b0, "R9 no write when full", mem_we_o, 0);
      check_flags();
      return;
    end
    a = slot_addr(base_i, ip);
    check(mem_we_o == 1'b1, "R2 low write enable", mem_we_o, 1);
    check(mem_addr_o == a, "R2 low address", mem_addr_o, a);
    check(mem_wdata_o == d[7:0], "R2 low byte", mem_wdata_o, d[7:0]);
    if (hold_busy) desc_i = ~d; else done_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    done_i = 1'b0;
    check(mem_we_o && mem_addr_o == a + 16'd1, "R2 high address", mem_addr_o, a + 16'd1);
    check(mem_wdata_o == d[15:8], "R2 high byte", mem_wdata_o, d[15:8]);
    @(posedge clk_i); @(negedge clk_i);
    ip = (ip + 1) % DEPTH;
    check(mem_we_o == 1'b0, hold_busy ? "R10 busy strobe ignored" : "R2 writes end", mem_we_o, 0);
    check_flags();
  endtask

  task automatic read_ptr(bit sel);
    logic [4:0] e;
    e = sel ? enc(ic) : enc(ip);
    rd_en_i = 1'b1; rd_sel_i = sel;
    @(posedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b0;
    if (sel) begin
      if (cnt() == 0) check(rd_data_o == e, "R7 empty pop value", rd_data_o, e);
      else begin
        check(rd_data_o == e, "R6 consumer read value", rd_data_o, e);
        ic = (ic + 1) % DEPTH;
        if (ic == 0) begin
          rd_en_i = 1'b1; rd_sel_i = 1'b0;
          @(posedge clk_i); @(negedge clk_i);
          rd_en_i = 1'b0;
        end
      end
    end else begin
      check(rd_data_o == e, "R5 producer read", rd_data_o, e);
      if (ip == 0) check(rd_data_o == 5'h1F, "R4 wrapped producer", rd_data_o, 5'h1F);
    end
    check_flags();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check(!pending_o && !overflow_o, "R1 flags after reset", {pending_o, overflow_o}, 0);
    check(mem_we_o == 1'b0, "R1 no write after reset", mem_we_o, 0);
    check(rd_data_o == 5'h00, "R1 read data after reset", rd_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    read_ptr(0);
    check(rd_data_o == 5'h1F, "R1 producer reset value", rd_data_o, 5'h1F);
    read_ptr(1);
    check(rd_data_o == 5'h1F, "R1 consumer reset value", rd_data_o, 5'h1F);
    read_ptr(1);
    read_ptr(0);
    // R3: three completions then drain
    for (int i = 0; i < 3; i++) begin
      complete(16'hA500 + 16'(i), 0);
      read_ptr(0);
    end
    for (int i = 0; i < 3; i++) read_ptr(1);
    read_ptr(1);
    // R4/R9: fill across wrap then overflow
    base_i = 16'h0100;
    for (int i = 0; i < DEPTH - 1; i++) complete(16'h1234 ^ 16'(i * 77), 0);
    read_ptr(0);
    complete(16'hDEAD, 0);
    read_ptr(0);
    complete(16'hBEEF, 0);
    for (int i = 0; i < DEPTH - 1; i++) read_ptr(1);
    read_ptr(1);
    // R10: strobe held during writes
    complete(16'h7777, 1);
    read_ptr(0);
    read_ptr(1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) complete(16'($urandom()), op == 0);
      else if (op < 8) read_ptr(1);
      else begin
        base_i = 16'($urandom());
        read_ptr(0);
      end
    end
    finish_run();
  end
endmodule